// File: doc/BRIEF.md
# Multiprocessor-Addressed Serial Receiver

This block rebuilds asynchronous serial characters from a single line input. An external rate generator supplies `os_tick`, a one-cycle pulse at sixteen times the bit rate. The receiver first passes the line through a synchronizer. It then finds the falling edge of a start bit and decides each bit by a majority of three samples. It assembles 8 or 9 data bits, least significant bit first, and then judges the stop bit. Each finished character is moved into a holding register together with its frame-error flag and its ninth bit, and a ready flag is raised.

Software reaches the block through a small register port. It reads the status register first and then the data register. Reading the data register releases the holding slot. Status reads have no side effect. A write to the data address is forwarded at once to the transmit side as a one-cycle strobe, `txw_valid` with `txw_data`. That strobe has no back-pressure: the transmit side must take it in the cycle it appears.

In multiprocessor mode each character is classified as an address or as data. Address characters are always delivered. Each one also selects or deselects this node by comparing it with a programmable own address. Data characters are dropped while the node is not selected.

Top module: `mp_uart_rx`

## Requirements
- R1: Each bit is decided by the majority of the samples taken at oversampling ticks 8, 9 and 10 of that bit, where the tick that detects the start edge is tick 0. A single disturbed sample does not change the received value.
- R2: A start bit whose majority reads one is treated as noise. The receiver returns to idle, delivers nothing, and still receives the next character correctly.
- R3: Every finished character that is delivered is loaded into the holding register and sets ready (status bit 0), even when the stop bit is bad. Frame error (status bit 1) is set when two or more stop samples are zero, and is cleared when the stop bit is good.
- R4: Data bits arrive least significant bit first. Reading the data register (address 0) returns the character and clears ready. Reading the status register (address 1) changes nothing.
- R5: With 9-bit mode enabled (control bit 1 at address 2), the ninth bit is captured into status bit 3 when the character is loaded. In 8-bit mode status bit 3 loads zero.
- R6: A character that finishes while ready is set is lost, and the holding register keeps the old character. Overrun (status bit 2) changes only when a ready character is read from the data register. At that read it takes the value that shows whether a character was lost before the read.
- R7: While enable (control bit 0) is clear, the receiver stays idle and ignores the line. The control register reads back as written in bits 2..0.
- R8: In multiprocessor mode (control bit 2) with 9-bit characters, a ninth bit of one marks an address character. The lower 8 bits of an address character are compared with the own address (address 3). A match sets node-selected (status bit 4) and a mismatch clears it.
- R9: In multiprocessor mode with 8-bit characters, a stop level of one marks an address character and a stop level of zero marks a data character.
- R10: In multiprocessor mode, address characters are always delivered. Data characters are delivered only while node-selected is set, and are otherwise dropped without touching ready or the holding register.
- R11: A write to address 0 raises `txw_valid` for that cycle, with `txw_data` equal to the written byte, and leaves the receive side unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | Oversampling pulse, 16 per bit |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 own address |
| bus_rd | input | 1 | Read strobe; side effects at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| txw_valid | output | 1 | Transmit-side write strobe |
| txw_data | output | 8 | Transmit-side write data |

## Verification
On every cycle the assertions check the following. A disabled receiver produces no character. Overrun moves only on a data read. A lost character leaves the holding register untouched. Delivery always raises ready, and a read clears it. Address characters always pass the filter, and unaddressed data never does. Only the bench scenarios can show the rest, because it depends on whole frames on the line. That covers the bit values after the majority vote, rejection of a noisy start, the LSB-first order, ninth-bit capture, stop-level classification in 8-bit mode, and the order in which overrun appears across several reads.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;

  localparam int ST_READY = 0;
  localparam int ST_FERR  = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_NINTH = 3;
  localparam int ST_SEL   = 4;

  localparam int CT_EN    = 0;
  localparam int CT_NINE  = 1;
  localparam int CT_MP    = 2;
endpackage

// File: rtl/umr_sync.sv
module umr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/umr_voter.sv
module umr_voter #(
  parameter int CW     = 4,
  parameter int SAMP_A = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          line,
  output logic          vote
);
  logic s0, s1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
    end else if (tick) begin
      if (cnt == CW'(SAMP_A))     s0 <= line;
      if (cnt == CW'(SAMP_A + 1)) s1 <= line;
    end
  end

  // third sample is the live line value at the deciding tick
  assign vote = (s0 & s1) | (s0 & line) | (s1 & line);
endmodule

// File: rtl/umr_framer.sv
module umr_framer
  import mp_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int SAMP_A    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               nine,
  input  logic               tick,
  input  logic               line,
  output logic               done,
  output logic [DATA_BITS:0] word,
  output logic               stop_lvl
);
  localparam int CW     = $clog2(OVS);
  localparam int BW     = $clog2(DATA_BITS + 2);
  localparam int SAMP_C = SAMP_A + 2;

  fr_state_e          state;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      idx;
  logic [DATA_BITS:0] shreg;
  logic               vote;
  logic [BW-1:0]      last_idx;
  logic               at_vote, at_end;

  umr_voter #(.CW(CW), .SAMP_A(SAMP_A)) voter_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!en),
    .tick (tick),
    .cnt  (cnt),
    .line (line),
    .vote (vote)
  );

  assign last_idx = nine ? BW'(DATA_BITS) : BW'(DATA_BITS - 1);
  assign at_vote  = (cnt == CW'(SAMP_C));
  assign at_end   = (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FR_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      word     <= '0;
      stop_lvl <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= FR_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          FR_IDLE: begin
            if (!line) begin
              state <= FR_START;
              cnt   <= CW'(1);
            end
          end
          FR_START: begin
            if (at_vote && vote) begin
              state <= FR_IDLE;
              cnt   <= '0;
            end else if (at_end) begin
              state <= FR_DATA;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          FR_DATA: begin
            if (at_vote) shreg[idx] <= vote;
            if (at_end) begin
              cnt <= '0;
              if (idx == last_idx) state <= FR_STOP;
              else                 idx   <= idx + BW'(1);
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          FR_STOP: begin
            if (at_vote) begin
              done     <= 1'b1;
              word     <= shreg;
              stop_lvl <= vote;
              state    <= FR_IDLE;
              cnt      <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/umr_mp_filter.sv
module umr_mp_filter #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS:0]   word,
  input  logic                 stop_lvl,
  input  logic                 mp_en,
  input  logic                 nine,
  input  logic [DATA_BITS-1:0] own_addr,
  output logic                 is_addr,
  output logic                 deliver,
  output logic                 selected
);
  assign is_addr = nine ? word[DATA_BITS] : stop_lvl;
  assign deliver = done && (!mp_en || is_addr || selected);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selected <= 1'b0;
    end else if (done && mp_en && is_addr) begin
      selected <= (word[DATA_BITS-1:0] == own_addr);
    end
  end
endmodule

// File: rtl/umr_regs.sv
module umr_regs
  import mp_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_BITS-1:0] bus_wdata,
  output logic [DATA_BITS-1:0] bus_rdata,
  output logic                 txw_valid,
  output logic [DATA_BITS-1:0] txw_data,
  input  logic                 deliver,
  input  logic [DATA_BITS:0]   word,
  input  logic                 stop_lvl,
  input  logic                 selected,
  output logic                 en,
  output logic                 nine,
  output logic                 mp_en,
  output logic [DATA_BITS-1:0] own_addr,
  output logic                 ready,
  output logic                 ovr_vis,
  output logic                 accept_rd,
  output logic [DATA_BITS-1:0] hold_data
);
  logic ferr, ninth, ovr_pend, slot_free;

  assign accept_rd = bus_rd && (bus_addr == REG_DATA) && ready;
  assign slot_free = !ready || accept_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      nine      <= 1'b0;
      mp_en     <= 1'b0;
      own_addr  <= '0;
      ready     <= 1'b0;
      ovr_vis   <= 1'b0;
      ovr_pend  <= 1'b0;
      ferr      <= 1'b0;
      ninth     <= 1'b0;
      hold_data <= '0;
    end else begin
      if (bus_wr && bus_addr == REG_CTRL) begin
        en    <= bus_wdata[CT_EN];
        nine  <= bus_wdata[CT_NINE];
        mp_en <= bus_wdata[CT_MP];
      end
      if (bus_wr && bus_addr == REG_OWN) own_addr <= bus_wdata;

      if (accept_rd) ovr_vis <= ovr_pend;

      if (deliver && !slot_free) ovr_pend <= 1'b1;
      else if (accept_rd)        ovr_pend <= 1'b0;

      if (deliver)        ready <= 1'b1;
      else if (accept_rd) ready <= 1'b0;

      if (deliver && slot_free) begin
        hold_data <= word[DATA_BITS-1:0];
        ferr      <= !stop_lvl;
        ninth     <= nine & word[DATA_BITS];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_DATA: bus_rdata = hold_data;
      REG_STAT: begin
        bus_rdata[ST_READY] = ready;
        bus_rdata[ST_FERR]  = ferr;
        bus_rdata[ST_OVR]   = ovr_vis;
        bus_rdata[ST_NINTH] = ninth;
        bus_rdata[ST_SEL]   = selected;
      end
      REG_CTRL: begin
        bus_rdata[CT_EN]   = en;
        bus_rdata[CT_NINE] = nine;
        bus_rdata[CT_MP]   = mp_en;
      end
      default: bus_rdata = own_addr;
    endcase
  end

  assign txw_valid = bus_wr && (bus_addr == REG_DATA);
  assign txw_data  = bus_wdata;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SAMP_A      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 os_tick,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_BITS-1:0] bus_wdata,
  output logic [DATA_BITS-1:0] bus_rdata,
  output logic                 txw_valid,
  output logic [DATA_BITS-1:0] txw_data
);
  logic                 line_s;
  logic                 frame_done, stop_lvl, is_addr, deliver, selected;
  logic [DATA_BITS:0]   word;
  logic                 en, nine, mp_en, ready, ovr_vis, accept_rd;
  logic [DATA_BITS-1:0] own_addr, hold_data;

  umr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(rx_line), .d_out(line_s)
  );

  umr_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS), .SAMP_A(SAMP_A)) framer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .nine(nine), .tick(os_tick),
    .line(line_s), .done(frame_done), .word(word), .stop_lvl(stop_lvl)
  );

  umr_mp_filter #(.DATA_BITS(DATA_BITS)) filter_i (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .word(word),
    .stop_lvl(stop_lvl), .mp_en(mp_en), .nine(nine), .own_addr(own_addr),
    .is_addr(is_addr), .deliver(deliver), .selected(selected)
  );

  umr_regs #(.DATA_BITS(DATA_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txw_valid(txw_valid), .txw_data(txw_data), .deliver(deliver),
    .word(word), .stop_lvl(stop_lvl), .selected(selected), .en(en),
    .nine(nine), .mp_en(mp_en), .own_addr(own_addr), .ready(ready),
    .ovr_vis(ovr_vis), .accept_rd(accept_rd), .hold_data(hold_data)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 frame_done,
  input logic                 deliver,
  input logic                 is_addr,
  input logic                 mp_en,
  input logic                 selected,
  input logic                 ready,
  input logic                 accept_rd,
  input logic                 ovr_vis,
  input logic [DATA_BITS-1:0] hold_data
);
  p_off_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !frame_done);

  p_ovr_only_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_rd |=> $stable(ovr_vis));

  p_lost_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && ready && !accept_rd) |=> $stable(hold_data));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_rd && !deliver) |=> !ready);

  p_deliver_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> ready);

  p_addr_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mp_en && is_addr) |-> deliver);

  p_drop_unsel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mp_en && !is_addr && !selected) |-> !deliver);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .frame_done(frame_done),
  .deliver(deliver), .is_addr(is_addr), .mp_en(mp_en), .selected(selected),
  .ready(ready), .accept_rd(accept_rd), .ovr_vis(ovr_vis),
  .hold_data(hold_data)
);

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] tdiv = '0;
  logic       os_tick;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       txw_valid;
  logic [7:0] txw_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  mp_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txw_valid(txw_valid), .txw_data(txw_data)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!os_tick);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic drive_bit(input logic val, input bit glitch);
    rx_line = val;
    wait_ticks(9);
    if (glitch) rx_line = ~val;
    wait_tick();
    rx_line = val;
    wait_ticks(6);
  endtask

  task automatic send(input logic [8:0] v, input int nb, input logic stop, input int gbit);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(v[i], i == gbit);
    drive_bit(stop, 1'b0);
    rx_line = 1'b1;
    wait_ticks(16);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp,
                            input logic [7:0] mask, input string tag);
    logic [7:0] d;
    bus_read(a, d);
    check(d & mask, exp & mask, tag);
  endtask

  task automatic t_reset();
    expect_reg(2'd1, 8'h00, 8'hFF, "R3 reset status");
    expect_reg(2'd2, 8'h00, 8'hFF, "R7 reset control");
  endtask

  task automatic t_basic();
    bus_write(2'd2, 8'h01);
    send(9'h05B, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h01, 8'h1F, "R3 ready after char");
    expect_reg(2'd1, 8'h01, 8'h1F, "R4 status read keeps ready");
    expect_reg(2'd0, 8'h5B, 8'hFF, "R4 data lsb first");
    expect_reg(2'd1, 8'h00, 8'h01, "R4 data read clears ready");
  endtask

  task automatic t_glitch();
    send(9'h0A5, 8, 1'b1, 2);
    expect_reg(2'd0, 8'hA5, 8'hFF, "R1 majority rejects one bad sample");
    send(9'h05A, 8, 1'b1, 7);
    expect_reg(2'd0, 8'h5A, 8'hFF, "R1 majority on msb");
  endtask

  task automatic t_noise_start();
    rx_line = 1'b0;
    wait_ticks(8);
    rx_line = 1'b1;
    wait_ticks(24);
    expect_reg(2'd1, 8'h00, 8'h01, "R2 noisy start dropped");
    send(9'h00F, 8, 1'b1, -1);
    expect_reg(2'd0, 8'h0F, 8'hFF, "R2 recovery after noise");
  endtask

  task automatic t_frame_err();
    send(9'h03C, 8, 1'b0, -1);
    expect_reg(2'd1, 8'h03, 8'h03, "R3 bad stop still delivered");
    expect_reg(2'd0, 8'h3C, 8'hFF, "R3 data with bad stop");
    send(9'h081, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h01, 8'h03, "R3 good stop clears frame error");
    expect_reg(2'd0, 8'h81, 8'hFF, "R3 data good stop");
  endtask

  task automatic t_nine();
    bus_write(2'd2, 8'h03);
    send(9'h13C, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h09, 8'h09, "R5 ninth bit one");
    expect_reg(2'd0, 8'h3C, 8'hFF, "R5 data nine-bit");
    send(9'h0C3, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h01, 8'h09, "R5 ninth bit zero");
    expect_reg(2'd0, 8'hC3, 8'hFF, "R5 data nine-bit second");
  endtask

  task automatic t_overrun();
    bus_write(2'd2, 8'h01);
    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h01, 8'h05, "R6 overrun not yet visible");
    expect_reg(2'd0, 8'h11, 8'hFF, "R6 old char kept");
    expect_reg(2'd1, 8'h04, 8'h05, "R6 overrun after read");
    send(9'h033, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h05, 8'h05, "R6 overrun held with next char");
    expect_reg(2'd0, 8'h33, 8'hFF, "R6 next char");
    expect_reg(2'd1, 8'h00, 8'h05, "R6 overrun cleared by read");
  endtask

  task automatic t_disable();
    bus_write(2'd2, 8'h00);
    send(9'h044, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h00, 8'h01, "R7 disabled ignores line");
    bus_write(2'd2, 8'h05);
    expect_reg(2'd2, 8'h05, 8'h07, "R7 control readback");
    bus_write(2'd2, 8'h01);
    expect_reg(2'd1, 8'h00, 8'h01, "R7 nothing after re-enable");
  endtask

  task automatic t_tx();
    @(negedge clk);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'hC3;
    #1;
    check({7'd0, txw_valid}, 8'h01, "R11 txw_valid on data write");
    check(txw_data, 8'hC3, "R11 txw_data");
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check({7'd0, txw_valid}, 8'h00, "R11 strobe one cycle");
    expect_reg(2'd1, 8'h00, 8'h01, "R11 write leaves rx ready");
    expect_reg(2'd0, 8'h33, 8'hFF, "R11 write leaves holding data");
  endtask

  task automatic t_mp9();
    bus_write(2'd3, 8'h5A);
    bus_write(2'd2, 8'h07);
    send(9'h011, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h00, 8'h01, "R10 data dropped unselected");
    send(9'h133, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h09, 8'h19, "R8 foreign address delivered");
    expect_reg(2'd0, 8'h33, 8'hFF, "R8 foreign address data");
    send(9'h044, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h00, 8'h01, "R10 still dropped");
    send(9'h15A, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h19, 8'h19, "R8 own address selects");
    expect_reg(2'd0, 8'h5A, 8'hFF, "R8 own address data");
    send(9'h077, 9, 1'b1, -1);
    expect_reg(2'd1, 8'h11, 8'h19, "R10 selected data delivered");
    expect_reg(2'd0, 8'h77, 8'hFF, "R10 selected data value");
  endtask

  task automatic t_mp8();
    bus_write(2'd2, 8'h05);
    send(9'h012, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h01, 8'h11, "R9 stop one is address, deselects");
    expect_reg(2'd0, 8'h12, 8'hFF, "R9 address data");
    send(9'h099, 8, 1'b0, -1);
    expect_reg(2'd1, 8'h00, 8'h01, "R9 stop zero data dropped");
    send(9'h05A, 8, 1'b1, -1);
    expect_reg(2'd1, 8'h11, 8'h11, "R9 own address selects");
    expect_reg(2'd0, 8'h5A, 8'hFF, "R9 own address value");
    send(9'h066, 8, 1'b0, -1);
    expect_reg(2'd1, 8'h13, 8'h13, "R9 selected data with stop zero");
    expect_reg(2'd0, 8'h66, 8'hFF, "R10 selected data 8-bit");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_noise_start();
    t_frame_err();
    t_nine();
    t_overrun();
    t_disable();
    t_tx();
    t_mp9();
    t_mp8();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule